// File: doc/BRIEF.md
# Self-Checking Byte Substitution Unit

This block performs the AES byte substitution on a single byte. A select input chooses the forward substitution or its inverse. The unit also checks every result while it runs. It takes the substituted byte and passes it through the opposite transform. It then compares the recovered byte with the byte that came in. If the two bytes differ, an error flag rises in the same cycle.

Both substitution maps are computed arithmetically and are not stored as tables. For the forward map, the unit takes the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with zero mapped to zero, and then applies the affine step with constant 0x63. The inverse map undoes the affine step and then takes the field inverse.

A test mask can be XORed onto the internal byte that feeds the checking transform. Fault handling can then be exercised without touching the substituted output. An optional registered copy of the flag holds any error until software or a controller issues a synchronous clear.

Top module: `sbox_selfcheck`

## Requirements
- R1: With `inv_sel` = 0, `sub_out` equals the forward AES S-box value of `sub_in`, for example 0x53 gives 0xED and 0x01 gives 0x7C.
- R2: With `inv_sel` = 1, `sub_out` equals the inverse S-box value of `sub_in`, so that inverse(forward(x)) = x for every byte x.
- R3: Zero has no field inverse and is treated as its own inverse. As a result, 0x00 maps forward to 0x63, and 0x63 maps back to 0x00.
- R4: While `flt_mask` is 0x00, `err_flag` stays low for every input byte in both modes.
- R5: Any nonzero `flt_mask` makes `err_flag` high in the same cycle, in either mode. The mask has no effect on `sub_out`.
- R6: When `err_flag` is high at a rising clock edge and `err_clr` is low, `err_latched` is high after that edge. It then stays high on every later edge while `err_clr` is low, even after `err_flag` has dropped.
- R7: When `err_clr` is high at a rising edge, `err_latched` is low after that edge, even if `err_flag` is high at the same time.
- R8: An active-low `rst_n` clears `err_latched` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held error flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_sel | input | 1 | 0 selects the forward map, 1 selects the inverse map |
| sub_in | input | DATA_W | Byte to substitute |
| flt_mask | input | DATA_W | Test mask XORed onto the internal checking byte |
| err_clr | input | 1 | Synchronous clear of the held flag |
| sub_out | output | DATA_W | Substituted byte |
| err_flag | output | 1 | Mismatch found by the round-trip compare in this cycle |
| err_latched | output | 1 | Held copy of err_flag |

## Verification
The sweep covers all 256 input bytes in both modes with the mask at zero. Each result is compared with maps that the bench builds by brute-force search for field inverses. Any bit of the affine step or the field arithmetic that goes wrong shows up as a value mismatch, and a broken checking path shows up as a false error. A second sweep applies each of the 255 nonzero masks in both modes. It confirms that the flag rises for every single-bit and multi-bit corruption while the output byte stays unchanged. Directed sequences on the held flag tell apart setting, holding, clear priority over a new error, and asynchronous reset.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] FWD_AFF_K = 8'h63;
   localparam logic [BYTE_W-1:0] INV_AFF_K = 8'h05;
   localparam logic [BYTE_W-1:0] RED_POLY  = 8'h1B;
   localparam logic [BYTE_W-1:0] INV_EXP   = 8'd254;

   function automatic logic [BYTE_W-1:0] xtime(input logic [BYTE_W-1:0] a);
      return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
   endfunction

   function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] acc = '0;
      logic [BYTE_W-1:0] sh  = a;
      for (int i = 0; i < BYTE_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = xtime(sh);
      end
      return acc;
   endfunction

   // x^254 equals x^-1 for nonzero x and yields zero for zero
   function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] x);
      logic [BYTE_W-1:0] res = 8'h01;
      logic [BYTE_W-1:0] pw  = x;
      for (int k = 0; k < BYTE_W; k++) begin
         if (INV_EXP[k]) res = gf_mul(res, pw);
         pw = gf_mul(pw, pw);
      end
      return res;
   endfunction

   function automatic logic [BYTE_W-1:0] aff_fwd(input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] o;
      for (int i = 0; i < BYTE_W; i++)
         o[i] = b[i] ^ b[(i+4)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+6)%BYTE_W]
              ^ b[(i+7)%BYTE_W] ^ FWD_AFF_K[i];
      return o;
   endfunction

   function automatic logic [BYTE_W-1:0] aff_inv(input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] o;
      for (int i = 0; i < BYTE_W; i++)
         o[i] = b[(i+2)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+7)%BYTE_W] ^ INV_AFF_K[i];
      return o;
   endfunction
endpackage

// File: rtl/sbox_fwd_map.sv
module sbox_fwd_map
   import sbox_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_i,
   output logic [BYTE_W-1:0] byte_o
);
   always_comb byte_o = aff_fwd(gf_inv(byte_i));
endmodule

// File: rtl/sbox_inv_map.sv
module sbox_inv_map
   import sbox_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_i,
   output logic [BYTE_W-1:0] byte_o
);
   always_comb byte_o = gf_inv(aff_inv(byte_i));
endmodule

// File: rtl/sbox_err_hold.sv
module sbox_err_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic hold_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_o <= 1'b0;
      else if (clr_i) hold_o <= 1'b0;
      else if (set_i) hold_o <= 1'b1;
   end
endmodule

// File: rtl/sbox_selfcheck.sv
module sbox_selfcheck #(
   parameter int DATA_W    = 8,
   parameter bit STICKY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_sel,
   input  logic [DATA_W-1:0] sub_in,
   input  logic [DATA_W-1:0] flt_mask,
   input  logic              err_clr,
   output logic [DATA_W-1:0] sub_out,
   output logic              err_flag,
   output logic              err_latched
);
   if (DATA_W != sbox_pkg::BYTE_W) begin : g_bad_width
      $error("sbox_selfcheck: DATA_W must be 8");
   end

   logic [DATA_W-1:0] fwd_first, inv_first;
   logic [DATA_W-1:0] mid_byte;
   logic [DATA_W-1:0] fwd_back, inv_back, back_byte;

   sbox_fwd_map u_fwd_first (.byte_i(sub_in),   .byte_o(fwd_first));
   sbox_inv_map u_inv_first (.byte_i(sub_in),   .byte_o(inv_first));
   sbox_fwd_map u_fwd_back  (.byte_i(mid_byte), .byte_o(fwd_back));
   sbox_inv_map u_inv_back  (.byte_i(mid_byte), .byte_o(inv_back));

   always_comb begin
      sub_out   = inv_sel ? inv_first : fwd_first;
      mid_byte  = sub_out ^ flt_mask;
      back_byte = inv_sel ? fwd_back : inv_back;
      err_flag  = (back_byte != sub_in);
   end

   if (STICKY_EN) begin : g_hold
      sbox_err_hold u_hold (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (err_flag),
         .clr_i (err_clr),
         .hold_o(err_latched)
      );
   end else begin : g_pass
      assign err_latched = err_flag;
   end
endmodule

// File: rtl/sbox_selfcheck_chk.sv
module sbox_selfcheck_chk #(
   parameter int DATA_W = 8,
   parameter bit STICKY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inv_sel,
   input logic [DATA_W-1:0] sub_in,
   input logic [DATA_W-1:0] flt_mask,
   input logic              err_clr,
   input logic [DATA_W-1:0] sub_out,
   input logic              err_flag,
   input logic              err_latched
);
   p_fwd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inv_sel && sub_in == 8'h00) |-> sub_out == 8'h63);
   p_inv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_sel && sub_in == 8'h63) |-> sub_out == 8'h00);
   p_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_mask == '0) |-> !err_flag);
   p_mask_detect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_mask != '0) |-> err_flag);

   if (STICKY) begin : g_sticky_props
      p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (err_flag && !err_clr) |=> err_latched);
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (err_latched && !err_clr) |=> err_latched);
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         err_clr |=> !err_latched);
   end
endmodule

bind sbox_selfcheck sbox_selfcheck_chk #(.DATA_W(DATA_W), .STICKY(STICKY_EN)) chk_i (
   .clk(clk), .rst_n(rst_n), .inv_sel(inv_sel), .sub_in(sub_in),
   .flt_mask(flt_mask), .err_clr(err_clr), .sub_out(sub_out),
   .err_flag(err_flag), .err_latched(err_latched)
);

// File: tb/sbox_selfcheck_tb.sv
module sbox_selfcheck_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       inv_sel = 1'b0;
   logic [7:0] sub_in = 8'h00;
   logic [7:0] flt_mask = 8'h00;
   logic       err_clr = 1'b0;
   logic [7:0] sub_out;
   logic       err_flag, err_latched;

   int checks = 0;
   int failures = 0;
   logic [7:0] fwd_t [256];
   logic [7:0] inv_t [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   sbox_selfcheck dut_i (
      .clk(clk), .rst_n(rst_n), .inv_sel(inv_sel), .sub_in(sub_in),
      .flt_mask(flt_mask), .err_clr(err_clr), .sub_out(sub_out),
      .err_flag(err_flag), .err_latched(err_latched)
   );

   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i-8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] ref_fwd(input logic [7:0] x);
      logic [7:0] v = 8'h00;
      logic [7:0] o;
      for (int y = 1; y < 256; y++) if (ref_mul(x, 8'(y)) == 8'h01) v = 8'(y);
      for (int i = 0; i < 8; i++)
         o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
      return o;
   endfunction

   task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic chk1(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int x = 0; x < 256; x++) fwd_t[x] = ref_fwd(8'(x));
      for (int x = 0; x < 256; x++) inv_t[fwd_t[x]] = 8'(x);

      repeat (2) @(negedge clk);
      chk1("R8 reset state", err_latched, 1'b0);
      rst_n = 1'b1;

      // R1/R2/R4: full sweep, clean path
      for (int m = 0; m < 2; m++) begin
         for (int x = 0; x < 256; x++) begin
            @(negedge clk);
            inv_sel = m[0]; sub_in = 8'(x); flt_mask = 8'h00;
            #1;
            if (m == 0) chk8("R1 forward map", sub_out, fwd_t[x]);
            else        chk8("R2 inverse map", sub_out, inv_t[x]);
            chk1("R4 no false error", err_flag, 1'b0);
         end
      end

      @(negedge clk); inv_sel = 0; sub_in = 8'h53; #1; chk8("R1 known 53", sub_out, 8'hED);
      @(negedge clk); sub_in = 8'h01; #1; chk8("R1 known 01", sub_out, 8'h7C);
      @(negedge clk); sub_in = 8'h00; #1; chk8("R3 zero forward", sub_out, 8'h63);
      @(negedge clk); inv_sel = 1; sub_in = 8'h63; #1; chk8("R3 zero inverse", sub_out, 8'h00);

      // R5: every nonzero mask, both modes
      for (int m = 0; m < 2; m++) begin
         for (int k = 1; k < 256; k++) begin
            @(negedge clk);
            err_clr = 1'b1;
            inv_sel = m[0]; sub_in = 8'(k * 37 + 11); flt_mask = 8'(k);
            #1;
            chk1("R5 mask detected", err_flag, 1'b1);
            chk8("R5 output unmasked", sub_out, m == 0 ? fwd_t[sub_in] : inv_t[sub_in]);
         end
      end
      @(negedge clk); flt_mask = 8'h00; sub_in = 8'h10; inv_sel = 0;
      @(posedge clk); #1; chk1("R7 cleared by clr", err_latched, 1'b0);

      // R6: set and hold
      @(negedge clk); err_clr = 1'b0; flt_mask = 8'h04;
      @(posedge clk); #1; chk1("R6 set", err_latched, 1'b1);
      @(negedge clk); flt_mask = 8'h00;
      @(posedge clk); @(posedge clk); #1;
      chk1("R6 hold", err_latched, 1'b1);
      chk1("R4 flag back low", err_flag, 1'b0);

      // R7: clear wins over a simultaneous error
      @(negedge clk); err_clr = 1'b1; flt_mask = 8'h80;
      @(posedge clk); #1; chk1("R7 clear priority", err_latched, 1'b0);
      @(negedge clk); err_clr = 1'b0; flt_mask = 8'h00;
      @(posedge clk); #1; chk1("R7 stays clear", err_latched, 1'b0);

      // R8: asynchronous reset
      @(negedge clk); flt_mask = 8'h01;
      @(posedge clk); #1; chk1("R6 set again", err_latched, 1'b1);
      @(negedge clk); flt_mask = 8'h00; rst_n = 1'b0;
      #1; chk1("R8 async reset", err_latched, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1; chk1("R8 stays clear", err_latched, 1'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule